// File: doc/BRIEF.md
# Mirror-Aware Memory Map Decoder

This block turns a 16-bit CPU address and the memory-request and opcode-fetch qualifiers into a ROM chip select, a RAM chip select, the address presented to the ROM and the physical offset presented to the RAM. The address space is split into eight 8k blocks. The lowest block always holds the ROM. Several other blocks repeat the ROM or the RAM, depending on two configuration inputs.

The first input picks the RAM size. With the small (1k) option, the first kilobyte repeats across the whole 16k RAM window, so only the low ten offset bits carry information. The second input enables the 32k expansion layout. In that layout, two of the ROM mirror blocks become RAM, each backed by its own 8k bank above the base 16k. The top 16k answers only to opcode fetches.

Two inhibit inputs let an expansion device claim a cycle by holding off the matching on-board chip select. The decoder is purely combinational and holds no state.

Top module: `memmap_decoder`

## Requirements
- R1: With memReqN low, addresses 0x0000–0x1FFF assert romCsN (low) and leave ramCsN high, in every configuration, unless romInhibit is high.
- R2: With expand32k low, 0x2000–0x3FFF and 0x8000–0xBFFF assert romCsN only.
- R3: With memReqN low, 0x4000–0x7FFF asserts ramCsN only. With ramIs1k low, ramAddr equals {1'b0, cpuAddr[13:0]}.
- R4: With ramIs1k high, every access to the base RAM window (0x4000–0x7FFF and its mirror at 0xC000–0xFFFF) gives ramAddr = {5'b0, cpuAddr[9:0]}.
- R5: With expand32k low, 0xC000–0xFFFF asserts ramCsN only. The offset is the one the matching address in 0x4000–0x7FFF would give, whatever opFetchN is.
- R6: With expand32k high, 0x2000–0x3FFF selects RAM at ramAddr = 0x4000 + cpuAddr[12:0] and 0x8000–0x9FFF selects RAM at 0x6000 + cpuAddr[12:0]. Neither is folded by ramIs1k. 0xA000–0xBFFF stays a ROM mirror.
- R7: With expand32k high, 0xC000–0xFFFF asserts ramCsN only while opFetchN is low, and asserts neither select while opFetchN is high.
- R8: While memReqN is high, both romCsN and ramCsN stay high.
- R9: romAddr always equals cpuAddr[12:0], whichever block is addressed.
- R10: romInhibit high forces romCsN high and ramInhibit high forces ramCsN high. Each leaves the other select unchanged.
- R11: romCsN and ramCsN are never low together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cpuAddr | input | 16 | CPU address bus |
| memReqN | input | 1 | Memory request, active low |
| opFetchN | input | 1 | Opcode-fetch cycle marker, active low |
| ramIs1k | input | 1 | 1 = 1k RAM option (fold to 10 bits), 0 = 16k |
| expand32k | input | 1 | 1 = expanded 32k layout |
| romInhibit | input | 1 | External hold-off of the ROM select, active high |
| ramInhibit | input | 1 | External hold-off of the RAM select, active high |
| romCsN | output | 1 | ROM chip select, active low |
| ramCsN | output | 1 | RAM chip select, active low |
| romAddr | output | 13 | Address presented to the ROM |
| ramAddr | output | 15 | Physical RAM offset (valid while ramCsN is low) |

## Verification
Every output is a pure function of the current inputs and is due in the same cycle, with no register in the path. The bench drives a new vector just after a rising clock edge and samples all outputs at the following falling edge. Any settling therefore finishes well before comparison. The RAM offset is compared only on vectors where the expected RAM select is active.

// File: rtl/memmap_pkg.sv
package memmap_pkg;
  parameter int ADDR_W      = 16;
  parameter int BLOCK_BITS  = 13;
  parameter int RAM_BASE_W  = 14;
  parameter int SMALL_RAM_W = 10;
  parameter int RAM_ADDR_W  = RAM_BASE_W + 1;
  parameter int BLK_W       = ADDR_W - BLOCK_BITS;

  typedef enum logic [1:0] {
    BANK_BASE   = 2'd0,
    BANK_EXP_LO = 2'd1,
    BANK_EXP_HI = 2'd2
  } bank_e;

  typedef struct packed {
    logic  romHit;
    logic  ramHit;
    bank_e bank;
  } strobe_t;
endpackage

// File: rtl/memmap_ctrl.sv
module memmap_ctrl
  import memmap_pkg::*;
(
  input  logic [BLK_W-1:0] blockIdx,
  input  logic             memReqN,
  input  logic             opFetchN,
  input  logic             expand32k,
  output strobe_t          strobes
);
  always_comb begin
    strobes = '{romHit: 1'b0, ramHit: 1'b0, bank: BANK_BASE};
    if (!memReqN) begin
      unique case (blockIdx)
        3'd0: strobes.romHit = 1'b1;
        3'd1: begin
          if (expand32k) begin
            strobes.ramHit = 1'b1;
            strobes.bank   = BANK_EXP_LO;
          end else begin
            strobes.romHit = 1'b1;
          end
        end
        3'd2, 3'd3: strobes.ramHit = 1'b1;
        3'd4: begin
          if (expand32k) begin
            strobes.ramHit = 1'b1;
            strobes.bank   = BANK_EXP_HI;
          end else begin
            strobes.romHit = 1'b1;
          end
        end
        3'd5: strobes.romHit = 1'b1;
        default: strobes.ramHit = !expand32k || !opFetchN;
      endcase
    end
  end
endmodule

// File: rtl/memmap_datapath.sv
module memmap_datapath
  import memmap_pkg::*;
(
  input  logic [RAM_BASE_W-1:0] lowAddr,
  input  strobe_t               strobes,
  input  logic                  ramIs1k,
  input  logic                  romInhibit,
  input  logic                  ramInhibit,
  output logic                  romCsN,
  output logic                  ramCsN,
  output logic [BLOCK_BITS-1:0] romAddr,
  output logic [RAM_ADDR_W-1:0] ramAddr
);
  logic [RAM_BASE_W-1:0] foldedBase;

  for (genvar i = 0; i < RAM_BASE_W; i++) begin : g_fold
    if (i < SMALL_RAM_W) begin : g_keep
      assign foldedBase[i] = lowAddr[i];
    end else begin : g_mask
      assign foldedBase[i] = lowAddr[i] & ~ramIs1k;
    end
  end

  always_comb begin
    unique case (strobes.bank)
      BANK_EXP_LO: ramAddr = {2'b10, lowAddr[BLOCK_BITS-1:0]};
      BANK_EXP_HI: ramAddr = {2'b11, lowAddr[BLOCK_BITS-1:0]};
      default:     ramAddr = {1'b0, foldedBase};
    endcase
  end

  assign romAddr = lowAddr[BLOCK_BITS-1:0];
  assign romCsN  = ~(strobes.romHit & ~romInhibit);
  assign ramCsN  = ~(strobes.ramHit & ~ramInhibit);
endmodule

// File: rtl/memmap_decoder.sv
module memmap_decoder
  import memmap_pkg::*;
(
  input  logic [ADDR_W-1:0]     cpuAddr,
  input  logic                  memReqN,
  input  logic                  opFetchN,
  input  logic                  ramIs1k,
  input  logic                  expand32k,
  input  logic                  romInhibit,
  input  logic                  ramInhibit,
  output logic                  romCsN,
  output logic                  ramCsN,
  output logic [BLOCK_BITS-1:0] romAddr,
  output logic [RAM_ADDR_W-1:0] ramAddr
);
  strobe_t strobes;

  memmap_ctrl u_ctrl (
    .blockIdx (cpuAddr[ADDR_W-1:BLOCK_BITS]),
    .memReqN  (memReqN),
    .opFetchN (opFetchN),
    .expand32k(expand32k),
    .strobes  (strobes)
  );

  memmap_datapath u_dp (
    .lowAddr   (cpuAddr[RAM_BASE_W-1:0]),
    .strobes   (strobes),
    .ramIs1k   (ramIs1k),
    .romInhibit(romInhibit),
    .ramInhibit(ramInhibit),
    .romCsN    (romCsN),
    .ramCsN    (ramCsN),
    .romAddr   (romAddr),
    .ramAddr   (ramAddr)
  );
endmodule

// File: rtl/memmap_checker.sv
module memmap_checker
  import memmap_pkg::*;
(
  input logic [ADDR_W-1:0]     cpuAddr,
  input logic                  memReqN,
  input logic                  opFetchN,
  input logic                  ramIs1k,
  input logic                  expand32k,
  input logic                  romInhibit,
  input logic                  ramInhibit,
  input logic                  romCsN,
  input logic                  ramCsN,
  input logic [RAM_ADDR_W-1:0] ramAddr
);
  logic inBaseWindow;
  assign inBaseWindow = cpuAddr[14] && !(cpuAddr[15] && expand32k);

  always_comb begin
    AST_ONE_SELECT: assert (romCsN || ramCsN);  // R11
    AST_IDLE_QUIET: assert (!memReqN || (romCsN && ramCsN));  // R8
    AST_BOOT_ROM: assert (memReqN || romInhibit || cpuAddr[15:13] != 3'd0 || !romCsN);  // R1
    AST_ROM_HOLDOFF: assert (!romInhibit || romCsN);  // R10
    AST_RAM_HOLDOFF: assert (!ramInhibit || ramCsN);  // R10
    AST_FOLD_1K: assert (ramCsN || !ramIs1k || !inBaseWindow
                         || ramAddr[RAM_ADDR_W-1:SMALL_RAM_W] == '0);  // R4
    AST_TOP_NEEDS_FETCH: assert (!expand32k || !opFetchN || cpuAddr[15:14] != 2'b11
                                 || (romCsN && ramCsN));  // R7
  end
endmodule

bind memmap_decoder memmap_checker u_chk (
  .cpuAddr   (cpuAddr),
  .memReqN   (memReqN),
  .opFetchN  (opFetchN),
  .ramIs1k   (ramIs1k),
  .expand32k (expand32k),
  .romInhibit(romInhibit),
  .ramInhibit(ramInhibit),
  .romCsN    (romCsN),
  .ramCsN    (ramCsN),
  .ramAddr   (ramAddr)
);

// File: tb/memmap_decoder_test.sv
module memmap_decoder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpuAddr = '0;
  logic        memReqN = 1'b1, opFetchN = 1'b1, ramIs1k = 1'b0, expand32k = 1'b0;
  logic        romInhibit = 1'b0, ramInhibit = 1'b0;
  logic        romCsN, ramCsN;
  logic [12:0] romAddr;
  logic [14:0] ramAddr;
  int          vectors = 0, miscompares = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  memmap_decoder uut (
    .cpuAddr(cpuAddr), .memReqN(memReqN), .opFetchN(opFetchN),
    .ramIs1k(ramIs1k), .expand32k(expand32k),
    .romInhibit(romInhibit), .ramInhibit(ramInhibit),
    .romCsN(romCsN), .ramCsN(ramCsN), .romAddr(romAddr), .ramAddr(ramAddr)
  );

  // Expected {romCsN, ramCsN, ramAddr}
  function automatic logic [16:0] model(input logic [15:0] a, input logic mr,
      input logic m1, input logic k1, input logic e, input logic ri, input logic ai);
    logic rom = 0, ram = 0;
    logic [14:0] off = '0;
    logic [2:0] b = a[15:13];
    if (!mr) begin
      if (b == 3'd0 || b == 3'd5) rom = 1;
      else if (b == 3'd1 || b == 3'd4) begin
        if (e) begin
          ram = 1;
          off = (b == 3'd1 ? 15'h4000 : 15'h6000) + {2'b00, a[12:0]};
        end else rom = 1;
      end else begin
        ram = (b == 3'd2 || b == 3'd3) ? 1'b1 : (!e || !m1);
        off = k1 ? {5'b0, a[9:0]} : {1'b0, a[13:0]};
      end
    end
    if (ri) rom = 0;
    if (ai) ram = 0;
    return {~rom, ~ram, off};
  endfunction

  task automatic apply(input logic [15:0] a, input logic mr, input logic m1,
      input logic k1, input logic e, input logic ri, input logic ai, input string req);
    logic [16:0] exp;
    @(posedge clk); #1;
    cpuAddr = a; memReqN = mr; opFetchN = m1; ramIs1k = k1; expand32k = e;
    romInhibit = ri; ramInhibit = ai;
    exp = model(a, mr, m1, k1, e, ri, ai);
    @(negedge clk);
    vectors++;
    if ({romCsN, ramCsN} !== exp[16:15]) begin
      miscompares++;
      $display("FAIL %s selects addr=%h: got rom=%b ram=%b expected rom=%b ram=%b",
               req, a, romCsN, ramCsN, exp[16], exp[15]);
    end
    if (romAddr !== a[12:0]) begin
      miscompares++;
      $display("FAIL R9 romAddr addr=%h: got %h expected %h", a, romAddr, a[12:0]);
    end
    if (!exp[15] && ramAddr !== exp[14:0]) begin
      miscompares++;
      $display("FAIL %s ramAddr addr=%h: got %h expected %h", req, a, ramAddr, exp[14:0]);
    end
  endtask

  initial begin
    #150000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int unused = $urandom(32'h1D0C);
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // idle state after reset: R8
    apply(16'h0000, 1, 1, 0, 0, 0, 0, "R8");
    apply(16'h4000, 1, 0, 0, 1, 0, 0, "R8");
    // R1 boot ROM in every mode
    apply(16'h0000, 0, 1, 0, 0, 0, 0, "R1");
    apply(16'h1FFF, 0, 0, 1, 1, 0, 0, "R1");
    // R2 stock ROM mirrors
    apply(16'h2000, 0, 1, 0, 0, 0, 0, "R2");
    apply(16'h9ABC, 0, 1, 0, 0, 0, 0, "R2");
    apply(16'hBFFF, 0, 1, 0, 0, 0, 0, "R2");
    // R3 / R4 RAM window
    apply(16'h4000, 0, 1, 0, 0, 0, 0, "R3");
    apply(16'h7FFF, 0, 1, 0, 0, 0, 0, "R3");
    apply(16'h7FFF, 0, 1, 1, 0, 0, 0, "R4");
    apply(16'h4400, 0, 1, 1, 0, 0, 0, "R4");
    apply(16'hC7FF, 0, 1, 1, 0, 0, 0, "R4");
    // R5 stock top mirror
    apply(16'hC123, 0, 1, 0, 0, 0, 0, "R5");
    apply(16'hFFFF, 0, 0, 0, 0, 0, 0, "R5");
    // R6 expansion banks and kept mirror
    apply(16'h2000, 0, 1, 0, 1, 0, 0, "R6");
    apply(16'h3FFF, 0, 1, 1, 1, 0, 0, "R6");
    apply(16'h8000, 0, 1, 0, 1, 0, 0, "R6");
    apply(16'h9FFF, 0, 1, 1, 1, 0, 0, "R6");
    apply(16'hA000, 0, 1, 0, 1, 0, 0, "R6");
    // R7 fetch-only top
    apply(16'hC000, 0, 0, 0, 1, 0, 0, "R7");
    apply(16'hC000, 0, 1, 0, 1, 0, 0, "R7");
    apply(16'hFFFF, 0, 1, 1, 1, 0, 0, "R7");
    // R10 inhibits, R11 exclusivity via every vector
    apply(16'h0100, 0, 1, 0, 0, 1, 0, "R10");
    apply(16'h0100, 0, 1, 0, 0, 0, 1, "R10");
    apply(16'h5000, 0, 1, 0, 0, 0, 1, "R10");
    apply(16'h5000, 0, 1, 0, 0, 1, 0, "R10");
    // constrained random mix, R11 exclusivity implied by the expected pair
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r = $urandom;
      apply(r[15:0], (r[19:16] == 0), r[20], r[21], r[22],
            (r[26:23] == 0), (r[30:27] == 0), "R11");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule